// File: doc/BRIEF.md
# Signalling Link Alignment Controller

This block sequences one signalling data link from out of service to in service. A start command begins a fixed exchange of link status indications: the block first sends "out of service" (SIOS), then "out of alignment" (SIO), then "normal" or "emergency" alignment (SIN or SIE). After a proving period it sends fill-in signal units (FISU). Decoded status indications from the far end arrive one at a time on a valid-qualified code input. The block answers with the status it wants transmitted and reports its link state.

A single shared down-counter runs off a slow timebase tick and supervises the four alignment timers. Only one timer is armed at any time. Local processor outage and local emergency are latched from set and clear commands. An external proving-failure input aborts proving. The initial indicator bits and sequence numbers are held for the transmit and receive logic next to this block.

Top module: `sig_link_align`

## Requirements
- R1: After reset, and whenever the link returns to out of service, link_state is 0 (out of service), tx_status is 3 (SIOS), fwd_ind and bwd_ind are 1, and fwd_seq and bwd_seq are 127. out_of_service is 1 only in state 0 and in_service is 1 only in state 6.
- R2: A start command in state 0 enters state 1 (not aligned), sends tx_status 0 (SIO) and arms T2. The T2_TICKS-th tick after entry returns the link to state 0.
- R3: In state 1, a valid received code 0, 1 or 2 (SIO, SIN, SIE) enters state 2 (aligned) and arms T3. The block sends 1 (SIN), or 2 (SIE) while local emergency is set. The T3_TICKS-th tick returns the link to state 0.
- R4: In state 2, a received SIN or SIE enters state 3 (proving), and a received code 3 (SIOS) returns the link to state 0. Other codes leave state 2 unchanged.
- R5: Proving lasts T4N_TICKS ticks. It lasts T4E_TICKS ticks when local emergency is set or the code that started proving was SIE. At the end of proving the link enters state 4 (aligned ready), sends 5 (FISU) and arms T1.
- R6: tx_status is never SIO while in state 3. In state 3, a received SIOS or an asserted prove_fail returns the link to state 0.
- R7: In state 4, a received code 5 or 6 (FISU, MSU) enters state 6 (in service) sending FISU. The T1_TICKS-th tick after T1 was armed returns the link to state 0.
- R8: A stop command in any state other than 0 returns the link to state 0 with SIOS on the next cycle.
- R9: A received SIO or SIOS in states 4, 5, 6 or 7 returns the link to state 0. A received code 4 (SIPO) in state 4 or 6 enters state 7 (processor outage).
- R10: If local outage is set when proving ends, the link enters state 5 (aligned not ready) sending 4 (SIPO). Setting or clearing outage moves the link between states 4 and 5 without restarting T1. In state 5 a received FISU or MSU enters state 7.
- R11: Setting outage in state 6 enters state 7 sending SIPO. State 7 sends SIPO while outage is set and FISU otherwise. It returns to state 6 when outage is clear and a FISU or MSU arrives.
- R12: A timer is armed in states 1 to 5 only: T2 in state 1, T3 in state 2, T4 in state 3, T1 in states 4 and 5. rx_code is ignored while rx_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase pulse that advances the timers |
| cmd_start | input | 1 | Begin alignment |
| cmd_stop | input | 1 | Deactivate the link |
| outage_set | input | 1 | Set local processor outage |
| outage_clr | input | 1 | Clear local processor outage |
| emerg_set | input | 1 | Set local emergency |
| emerg_clr | input | 1 | Clear local emergency |
| rx_valid | input | 1 | rx_code is valid this cycle |
| rx_code | input | 3 | Received indication: 0 SIO, 1 SIN, 2 SIE, 3 SIOS, 4 SIPO, 5 FISU, 6 MSU |
| prove_fail | input | 1 | Proving period failed |
| tx_status | output | 3 | Status to transmit, same codes as rx_code (0 to 5) |
| link_state | output | 3 | Current link state, 0 to 7 |
| in_service | output | 1 | Link is in service |
| out_of_service | output | 1 | Link is out of service |
| fwd_ind | output | 1 | Initial forward indicator bit |
| bwd_ind | output | 1 | Initial backward indicator bit |
| fwd_seq | output | 7 | Initial forward sequence number |
| bwd_seq | output | 7 | Initial backward sequence number |

## Verification
The bench builds the block with T1_TICKS=6, T2_TICKS=5, T3_TICKS=4, T4N_TICKS=7 and T4E_TICKS=3. With these values every timer can be driven to one tick before its limit and then to its limit within a few cycles. The same short limits make it cheap to reach each of the seven active states and apply all seven received codes, so the whole state-by-indication table is swept. Stop is checked from every state, and the emergency, outage and T1 carry-over paths each get their own sequence.

// File: rtl/sla_pkg.sv
package sla_pkg;

    typedef enum logic [2:0] {
        LS_OOS    = 3'd0,
        LS_NOTALN = 3'd1,
        LS_ALN    = 3'd2,
        LS_PROVE  = 3'd3,
        LS_RDY    = 3'd4,
        LS_NRDY   = 3'd5,
        LS_INSVC  = 3'd6,
        LS_POUT   = 3'd7
    } link_st_e;

    localparam logic [2:0] SU_SIO  = 3'd0;
    localparam logic [2:0] SU_SIN  = 3'd1;
    localparam logic [2:0] SU_SIE  = 3'd2;
    localparam logic [2:0] SU_SIOS = 3'd3;
    localparam logic [2:0] SU_SIPO = 3'd4;
    localparam logic [2:0] SU_FISU = 3'd5;
    localparam logic [2:0] SU_MSU  = 3'd6;

    typedef enum logic [2:0] {
        TM_NONE = 3'd0,
        TM_T1   = 3'd1,
        TM_T2   = 3'd2,
        TM_T3   = 3'd3,
        TM_T4   = 3'd4
    } tmr_e;

    localparam logic [6:0] SEQ_INIT = 7'h7F;

endpackage

// File: rtl/sla_flags.sv
module sla_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic outage_set,
    input  logic outage_clr,
    input  logic emerg_set,
    input  logic emerg_clr,
    output logic outage,
    output logic emerg
);
    typedef struct packed {
        logic lpo;
        logic emg;
    } flags_t;

    flags_t f_q, f_d;

    always_comb begin
        f_d = f_q;
        if (outage_set)      f_d.lpo = 1'b1;
        else if (outage_clr) f_d.lpo = 1'b0;
        if (emerg_set)       f_d.emg = 1'b1;
        else if (emerg_clr)  f_d.emg = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign outage = f_q.lpo;
    assign emerg  = f_q.emg;

    // set wins over clear (R10)
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        outage_set |=> outage);

endmodule

// File: rtl/sla_timer.sv
module sla_timer
    import sla_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic          clear,
    input  tmr_e          load_id,
    input  logic [CW-1:0] load_val,
    output tmr_e          armed,
    output logic          expire
);
    typedef struct packed {
        tmr_e          id;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_q, t_d;

    always_comb begin
        t_d    = t_q;
        expire = (t_q.id != TM_NONE) && tick && (t_q.cnt == CW'(1));
        if (load) begin
            t_d.id  = load_id;
            t_d.cnt = load_val;
        end else if (clear || expire) begin
            t_d.id  = TM_NONE;
            t_d.cnt = '0;
        end else if ((t_q.id != TM_NONE) && tick) begin
            t_d.cnt = t_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{id: TM_NONE, cnt: '0};
        else        t_q <= t_d;
    end

    assign armed = t_q.id;

    // an armed timer always has ticks left to count (R12)
    p_armed_nonzero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.id != TM_NONE) |-> (t_q.cnt != '0));

    // expiry disarms unless a new timer is loaded at once (R12)
    p_expire_disarms_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load) |=> (armed == TM_NONE));

endmodule

// File: rtl/sig_link_align.sv
module sig_link_align
    import sla_pkg::*;
#(
    parameter int T1_TICKS  = 450,
    parameter int T2_TICKS  = 100,
    parameter int T3_TICKS  = 13,
    parameter int T4N_TICKS = 82,
    parameter int T4E_TICKS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cmd_start,
    input  logic       cmd_stop,
    input  logic       outage_set,
    input  logic       outage_clr,
    input  logic       emerg_set,
    input  logic       emerg_clr,
    input  logic       rx_valid,
    input  logic [2:0] rx_code,
    input  logic       prove_fail,
    output logic [2:0] tx_status,
    output logic [2:0] link_state,
    output logic       in_service,
    output logic       out_of_service,
    output logic       fwd_ind,
    output logic       bwd_ind,
    output logic [6:0] fwd_seq,
    output logic [6:0] bwd_seq
);
    localparam int M12  = (T1_TICKS > T2_TICKS) ? T1_TICKS : T2_TICKS;
    localparam int M34  = (T3_TICKS > T4N_TICKS) ? T3_TICKS : T4N_TICKS;
    localparam int M124 = (M12 > M34) ? M12 : M34;
    localparam int MAXT = (M124 > T4E_TICKS) ? M124 : T4E_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    typedef struct packed {
        link_st_e   st;
        logic [2:0] tx;
        logic       fib;
        logic       bib;
        logic [6:0] fsn;
        logic [6:0] bsn;
    } ctl_t;

    ctl_t c_q, c_d;

    logic          lpo, emg;
    logic          t_load, t_clear, t_exp;
    tmr_e          t_id, t_armed;
    logic [CW-1:0] t_val;

    sla_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .outage_set(outage_set),
        .outage_clr(outage_clr),
        .emerg_set (emerg_set),
        .emerg_clr (emerg_clr),
        .outage    (lpo),
        .emerg     (emg)
    );

    sla_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (t_load),
        .clear   (t_clear),
        .load_id (t_id),
        .load_val(t_val),
        .armed   (t_armed),
        .expire  (t_exp)
    );

    logic rx_align, rx_prove, rx_drop, rx_traffic, rx_po;
    assign rx_align   = rx_valid && (rx_code == SU_SIO || rx_code == SU_SIN || rx_code == SU_SIE);
    assign rx_prove   = rx_valid && (rx_code == SU_SIN || rx_code == SU_SIE);
    assign rx_drop    = rx_valid && (rx_code == SU_SIO || rx_code == SU_SIOS);
    assign rx_traffic = rx_valid && (rx_code == SU_FISU || rx_code == SU_MSU);
    assign rx_po      = rx_valid && (rx_code == SU_SIPO);

    logic [2:0] align_tx;
    assign align_tx = emg ? SU_SIE : SU_SIN;

    always_comb begin
        c_d     = c_q;
        t_load  = 1'b0;
        t_clear = 1'b0;
        t_id    = TM_NONE;
        t_val   = '0;
        unique case (c_q.st)
            LS_OOS: begin
                c_d.tx = SU_SIOS;
                if (cmd_start) begin
                    c_d.st = LS_NOTALN;
                    c_d.tx = SU_SIO;
                    t_load = 1'b1;
                    t_id   = TM_T2;
                    t_val  = CW'(T2_TICKS);
                end
            end
            LS_NOTALN: begin
                if (t_exp) begin
                    c_d.st = LS_OOS;
                end else if (rx_align) begin
                    c_d.st = LS_ALN;
                    c_d.tx = align_tx;
                    t_load = 1'b1;
                    t_id   = TM_T3;
                    t_val  = CW'(T3_TICKS);
                end
            end
            LS_ALN: begin
                c_d.tx = align_tx;
                if (t_exp || (rx_valid && rx_code == SU_SIOS)) begin
                    c_d.st = LS_OOS;
                end else if (rx_prove) begin
                    c_d.st = LS_PROVE;
                    t_load = 1'b1;
                    t_id   = TM_T4;
                    t_val  = (emg || rx_code == SU_SIE) ? CW'(T4E_TICKS) : CW'(T4N_TICKS);
                end
            end
            LS_PROVE: begin
                c_d.tx = align_tx;
                if (t_exp) begin
                    c_d.st = lpo ? LS_NRDY : LS_RDY;
                    c_d.tx = lpo ? SU_SIPO : SU_FISU;
                    t_load = 1'b1;
                    t_id   = TM_T1;
                    t_val  = CW'(T1_TICKS);
                end else if (prove_fail || (rx_valid && rx_code == SU_SIOS)) begin
                    c_d.st = LS_OOS;
                end
            end
            LS_RDY: begin
                if (t_exp || rx_drop) begin
                    c_d.st = LS_OOS;
                end else if (rx_po) begin
                    c_d.st = LS_POUT;
                    c_d.tx = SU_FISU;
                end else if (rx_traffic) begin
                    c_d.st = LS_INSVC;
                    c_d.tx = SU_FISU;
                end else if (lpo) begin
                    c_d.st = LS_NRDY;
                    c_d.tx = SU_SIPO;
                end
            end
            LS_NRDY: begin
                if (t_exp || rx_drop) begin
                    c_d.st = LS_OOS;
                end else if (rx_traffic) begin
                    c_d.st = LS_POUT;
                    c_d.tx = SU_SIPO;
                end else if (!lpo) begin
                    c_d.st = LS_RDY;
                    c_d.tx = SU_FISU;
                end
            end
            LS_INSVC: begin
                if (rx_drop) begin
                    c_d.st = LS_OOS;
                end else if (rx_po) begin
                    c_d.st = LS_POUT;
                    c_d.tx = SU_FISU;
                end else if (lpo) begin
                    c_d.st = LS_POUT;
                    c_d.tx = SU_SIPO;
                end
            end
            LS_POUT: begin
                c_d.tx = lpo ? SU_SIPO : SU_FISU;
                if (rx_drop) begin
                    c_d.st = LS_OOS;
                end else if (!lpo && rx_traffic) begin
                    c_d.st = LS_INSVC;
                    c_d.tx = SU_FISU;
                end
            end
            default: c_d.st = LS_OOS;
        endcase

        if (cmd_stop && c_q.st != LS_OOS) begin
            c_d.st = LS_OOS;
            t_load = 1'b0;
        end
        if (c_d.st == LS_OOS) begin
            c_d.tx  = SU_SIOS;
            c_d.fib = 1'b1;
            c_d.bib = 1'b1;
            c_d.fsn = SEQ_INIT;
            c_d.bsn = SEQ_INIT;
        end
        if (c_d.st == LS_OOS || c_d.st == LS_INSVC || c_d.st == LS_POUT)
            t_clear = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: LS_OOS, tx: SU_SIOS, fib: 1'b1, bib: 1'b1,
                            fsn: SEQ_INIT, bsn: SEQ_INIT};
        else        c_q <= c_d;
    end

    assign tx_status      = c_q.tx;
    assign link_state     = c_q.st;
    assign in_service     = (c_q.st == LS_INSVC);
    assign out_of_service = (c_q.st == LS_OOS);
    assign fwd_ind        = c_q.fib;
    assign bwd_ind        = c_q.bib;
    assign fwd_seq        = c_q.fsn;
    assign bwd_seq        = c_q.bsn;

    p_oos_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == LS_OOS) |-> (c_q.tx == SU_SIOS && c_q.fib && c_q.bib &&
                                c_q.fsn == SEQ_INIT && c_q.bsn == SEQ_INIT));

    p_no_sio_prove_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == LS_PROVE) |-> (c_q.tx != SU_SIO));

    p_prove_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == LS_PROVE && prove_fail && !t_exp) |=> (c_q.st == LS_OOS));

    p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> (c_q.st == LS_OOS));

    p_t2_owner_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == LS_NOTALN) |-> (t_armed == TM_T2));

    p_t1_owner_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == LS_RDY || c_q.st == LS_NRDY) |-> (t_armed == TM_T1));

    p_idle_timer_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == LS_OOS || c_q.st == LS_INSVC || c_q.st == LS_POUT) |-> (t_armed == TM_NONE));

    p_insvc_fisu_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == LS_INSVC) |-> (c_q.tx == SU_FISU));

endmodule

// File: tb/test_sig_link_align.sv
module test_sig_link_align;
    localparam int T1 = 6, T2 = 5, T3 = 4, T4N = 7, T4E = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick = 0, cmd_start = 0, cmd_stop = 0;
    logic outage_set = 0, outage_clr = 0, emerg_set = 0, emerg_clr = 0;
    logic rx_valid = 0, prove_fail = 0;
    logic [2:0] rx_code = 3'd0;
    logic [2:0] tx_status, link_state;
    logic in_service, out_of_service, fwd_ind, bwd_ind;
    logic [6:0] fwd_seq, bwd_seq;

    int vectors = 0, miscompares = 0, cycles = 0;

    always #5 clk = ~clk;

    sig_link_align #(.T1_TICKS(T1), .T2_TICKS(T2), .T3_TICKS(T3),
                     .T4N_TICKS(T4N), .T4E_TICKS(T4E)) i_sig_link_align (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .outage_set(outage_set), .outage_clr(outage_clr),
        .emerg_set(emerg_set), .emerg_clr(emerg_clr), .rx_valid(rx_valid),
        .rx_code(rx_code), .prove_fail(prove_fail), .tx_status(tx_status),
        .link_state(link_state), .in_service(in_service),
        .out_of_service(out_of_service), .fwd_ind(fwd_ind), .bwd_ind(bwd_ind),
        .fwd_seq(fwd_seq), .bwd_seq(bwd_seq));

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            $display("FAIL watchdog: act=%0d cycles exp=completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares + 1);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic st_chk(input string tag, input int s, input int tx);
        check({tag, " state"}, int'(link_state), s);
        check({tag, " tx"}, int'(tx_status), tx);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        tick = 1;
        for (int i = 0; i < n; i++) @(negedge clk);
        tick = 0;
    endtask

    task automatic rx(input int k);
        rx_valid = 1; rx_code = 3'(k);
        @(negedge clk);
        rx_valid = 0;
    endtask

    // states: 0 oos 1 notaln 2 aln 3 prove 4 rdy 5 nrdy 6 insvc 7 pout
    task automatic reach(input int s);
        cmd_stop = 1; outage_clr = 1; emerg_clr = 1;
        @(negedge clk);
        cmd_stop = 0; outage_clr = 0; emerg_clr = 0;
        if (s >= 1) begin cmd_start = 1; @(negedge clk); cmd_start = 0; end
        if (s >= 2) rx(0);
        if (s >= 3) rx(1);
        if (s == 5) begin outage_set = 1; @(negedge clk); outage_set = 0; end
        if (s >= 4) ticks(T4N);
        if (s >= 6) rx(5);
        if (s == 7) rx(4);
    endtask

    function automatic int exp_next(input int s, input int k);
        bit drop = (k == 0 || k == 3), trf = (k == 5 || k == 6);
        case (s)
            1: return (k <= 2) ? 2 : 1;
            2: return (k == 1 || k == 2) ? 3 : (k == 3) ? 0 : 2;
            3: return (k == 3) ? 0 : 3;
            4: return drop ? 0 : (k == 4) ? 7 : trf ? 6 : 4;
            5: return drop ? 0 : trf ? 7 : 5;
            6: return drop ? 0 : (k == 4) ? 7 : 6;
            7: return drop ? 0 : trf ? 6 : 7;
            default: return 0;
        endcase
    endfunction

    // tx per state with emergency clear; outage set only in state 5 paths
    function automatic int exp_tx(input int s, input bit lpo_on);
        case (s)
            0: return 3;
            1: return 0;
            2, 3: return 1;
            5: return 4;
            7: return lpo_on ? 4 : 5;
            default: return 5;
        endcase
    endfunction

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        st_chk("R1 reset", 0, 3);
        check("R1 fwd_ind", fwd_ind, 1);
        check("R1 bwd_ind", bwd_ind, 1);
        check("R1 fwd_seq", fwd_seq, 127);
        check("R1 bwd_seq", bwd_seq, 127);
        check("R1 oos flag", out_of_service, 1);
        check("R1 insvc flag", in_service, 0);

        // R2 start and T2 boundary
        reach(1);
        st_chk("R2 start", 1, 0);
        ticks(T2 - 1);
        st_chk("R2 T2-1", 1, 0);
        ticks(1);
        st_chk("R2 T2 expiry", 0, 3);

        // R12 rx ignored without valid
        reach(1);
        rx_code = 3'd0; @(negedge clk);
        st_chk("R12 rx_valid low", 1, 0);

        // R3 T3 boundary
        reach(2);
        st_chk("R3 aligned", 2, 1);
        ticks(T3 - 1);
        st_chk("R3 T3-1", 2, 1);
        ticks(1);
        st_chk("R3 T3 expiry", 0, 3);

        // R5 normal proving, R7 T1 boundary
        reach(3);
        ticks(T4N - 1);
        st_chk("R5 T4N-1", 3, 1);
        ticks(1);
        st_chk("R5 T4N end", 4, 5);
        ticks(T1 - 1);
        st_chk("R7 T1-1", 4, 5);
        ticks(1);
        st_chk("R7 T1 expiry", 0, 3);

        // R3/R5 local emergency: SIE sent, short proving
        reach(0);
        emerg_set = 1; @(negedge clk); emerg_set = 0;
        cmd_start = 1; @(negedge clk); cmd_start = 0;
        rx(0);
        st_chk("R3 emergency tx", 2, 2);
        rx(1);
        st_chk("R6 emergency prove", 3, 2);
        ticks(T4E - 1);
        check("R5 T4E-1 local", link_state, 3);
        ticks(1);
        st_chk("R5 T4E end local", 4, 5);

        // R5 remote emergency via SIE
        reach(2);
        rx(2);
        ticks(T4E - 1);
        check("R5 T4E-1 remote", link_state, 3);
        ticks(1);
        check("R5 T4E end remote", link_state, 4);

        // R6 prove failure
        reach(3);
        prove_fail = 1; @(negedge clk); prove_fail = 0;
        st_chk("R6 prove_fail", 0, 3);

        // R10 outage toggling keeps T1 running
        reach(4);
        ticks(2);
        outage_set = 1; @(negedge clk); outage_set = 0;
        @(negedge clk);
        st_chk("R10 to not ready", 5, 4);
        outage_clr = 1; @(negedge clk); outage_clr = 0;
        @(negedge clk);
        st_chk("R10 back ready", 4, 5);
        ticks(T1 - 3);
        check("R10 T1 carried -1", link_state, 4);
        ticks(1);
        check("R10 T1 carried expiry", link_state, 0);

        // R10 outage at proving end
        reach(5);
        st_chk("R10 proving end outage", 5, 4);

        // R11 outage in service and recovery
        reach(6);
        check("R7 in_service flag", in_service, 1);
        outage_set = 1; @(negedge clk); outage_set = 0;
        @(negedge clk);
        st_chk("R11 outage in service", 7, 4);
        outage_clr = 1; @(negedge clk); outage_clr = 0;
        @(negedge clk);
        st_chk("R11 outage cleared", 7, 5);
        rx(6);
        st_chk("R11 resume", 6, 5);

        // R8 stop from every active state
        for (int s = 1; s <= 7; s++) begin
            reach(s);
            cmd_stop = 1; @(negedge clk); cmd_stop = 0;
            st_chk($sformatf("R8 stop from %0d", s), 0, 3);
            check("R8 oos flag", out_of_service, 1);
        end

        // R4 R6 R7 R9 R10 R11: state x received code sweep
        for (int s = 1; s <= 7; s++) begin
            for (int k = 0; k <= 6; k++) begin
                int e;
                reach(s);
                rx(k);
                e = exp_next(s, k);
                st_chk($sformatf("R9 sweep s=%0d k=%0d", s, k), e, exp_tx(e, s == 5));
                check("R1 insvc flag sweep", in_service, (e == 6) ? 1 : 0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule